// File: doc/BRIEF.md
# Interrupt Destination Address Matcher

This block decides, for each interrupt message that reaches a local interrupt unit, whether that unit is one of the targets. A message carries a two-bit shorthand code, a mode bit that selects physical or logical addressing, an eight-bit destination field, and a flag that says the message was sent by this same unit. The block applies the shorthand first. When the shorthand code is zero, the destination field is compared against local state instead.

Three local registers hold that state: an identity register, a logical-destination register and a format register. The format register selects how logical destinations are read. In flat form, each destination bit picks one unit. In cluster form, the upper nibble names a cluster and the lower nibble is a member bitmap. Software loads the registers, and reads them back, over a simple word-wide register port.

The decision for a message presented in one cycle is registered and appears on the outputs in the next cycle, with a valid strobe. A separate flag reports when the format register holds a value that is not recognised.

Top module: `dest_match`

## Requirements
- R1: After reset the identity register reads 0x00000000, the logical-destination register reads 0x00000000, the format register reads 0xFFFFFFFF, and both `hit_vld` and `hit` are 0.
- R2: Physical addressing (shorthand 00, `msg_logical`=0) hits when the destination is 0xFF or when it equals identity-register bits [31:24].
- R3: Flat logical addressing (shorthand 00, `msg_logical`=1, format bits [31:28]=0xF) hits when logical-destination bits [31:24] ANDed with the destination give a nonzero result.
- R4: Cluster logical addressing (format bits [31:28]=0x0) hits only when the upper nibble of logical-destination bits [31:24] equals the upper nibble of the destination and the AND of the two lower nibbles is nonzero.
- R5: Shorthand 01 hits only when `msg_self`=1, shorthand 10 always hits, and shorthand 11 hits only when `msg_self`=0. With a nonzero shorthand, the destination field and the mode bit have no effect.
- R6: A write to the format register stores the written bits [31:28] and forces bits [27:0] to ones. The stored value reads back that way.
- R7: When format bits [31:28] are neither 0xF nor 0x0, `fmt_bad` is 1 and logical addressing never hits. Physical addressing is not affected by the format value.
- R8: `hit_vld` is 1 exactly in the cycle after a cycle with `msg_valid`=1. `hit` is 0 whenever `hit_vld` is 0.
- R9: Register select codes are 0 for identity, 1 for logical destination and 2 for format. Writes to select code 3 change no register, and reads of code 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 identity, 1 logical destination, 2 format |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| msg_valid | input | 1 | A message is presented this cycle |
| msg_shorthand | input | 2 | 00 uses the destination field, 01 self, 10 all including self, 11 all excluding self |
| msg_logical | input | 1 | 1 selects logical addressing, 0 selects physical addressing |
| msg_dest | input | 8 | Destination field |
| msg_self | input | 1 | The message was sent by this unit |
| hit_vld | output | 1 | A decision is available this cycle |
| hit | output | 1 | This unit is a target of the message |
| fmt_bad | output | 1 | Format register upper nibble is neither 0xF nor 0x0 |

## Verification
The hardest case to reach is the unrecognised format. Because every write forces the lower 28 bits to ones, the only way in is a write with an upper nibble other than 0x0 or 0xF. The stimulus writes such a value, such as 0x5, and then sends a logical message whose destination overlaps the logical ID in both the flat and the cluster sense. A match in either interpretation would give a false hit, so the expected result of no hit is a real check. A physical broadcast is sent in the same state to show that physical addressing still works while the format is invalid.

// File: rtl/dest_match.sv
module dest_match #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          msg_valid,
  input  logic [1:0]    msg_shorthand,
  input  logic          msg_logical,
  input  logic [AW-1:0] msg_dest,
  input  logic          msg_self,
  output logic          hit_vld,
  output logic          hit,
  output logic          fmt_bad
);
  localparam int NW = AW / 2;
  localparam logic [DW-1:0] FMT_FORCE = {4'h0, {(DW-4){1'b1}}};

  logic [DW-1:0] id_q, ldr_q, fmt_q;
  logic [AW-1:0] my_id, my_log;
  logic          phys_hit, flat_hit, clus_hit, log_hit, dst_hit, now_hit;
  logic          fmt_flat, fmt_clus;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q  <= '0;
      ldr_q <= '0;
      fmt_q <= '1;
    end else if (reg_wr) begin
      case (reg_sel)
        2'd0:    id_q  <= reg_wdata;
        2'd1:    ldr_q <= reg_wdata;
        2'd2:    fmt_q <= reg_wdata | FMT_FORCE;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = id_q;
      2'd1:    reg_rdata = ldr_q;
      2'd2:    reg_rdata = fmt_q;
      default: reg_rdata = '0;
    endcase
  end

  assign my_id    = id_q[DW-1 -: AW];
  assign my_log   = ldr_q[DW-1 -: AW];
  assign fmt_flat = (fmt_q[DW-1 -: 4] == 4'hF);
  assign fmt_clus = (fmt_q[DW-1 -: 4] == 4'h0);
  assign fmt_bad  = !fmt_flat && !fmt_clus;

  assign phys_hit = (msg_dest == {AW{1'b1}}) || (msg_dest == my_id);
  assign flat_hit = |(my_log & msg_dest);
  assign clus_hit = (my_log[AW-1 -: NW] == msg_dest[AW-1 -: NW]) &&
                    (|(my_log[NW-1:0] & msg_dest[NW-1:0]));
  assign log_hit  = fmt_flat ? flat_hit : (fmt_clus ? clus_hit : 1'b0);
  assign dst_hit  = msg_logical ? log_hit : phys_hit;

  always_comb begin
    case (msg_shorthand)
      2'b00:   now_hit = dst_hit;
      2'b01:   now_hit = msg_self;
      2'b10:   now_hit = 1'b1;
      default: now_hit = !msg_self;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_vld <= 1'b0;
      hit     <= 1'b0;
    end else begin
      hit_vld <= msg_valid;
      hit     <= msg_valid && now_hit;
    end
  end

  assert_bcast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_shorthand == 2'b00 && !msg_logical && msg_dest == {AW{1'b1}}) |=> hit);

  assert_allinc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_shorthand == 2'b10) |=> hit);

  assert_selfonly_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_shorthand == 2'b01 && !msg_self) |=> !hit);

  assert_badfmt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_shorthand == 2'b00 && msg_logical && fmt_bad) |=> !hit);

  assert_fmtwr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd2) |=> (fmt_q[DW-5:0] == {(DW-4){1'b1}} &&
                                     fmt_q[DW-1 -: 4] == $past(reg_wdata[DW-1 -: 4])));

  assert_vld_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> hit_vld);

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> (!hit_vld && !hit));
endmodule

// File: tb/dest_match_tb_top.sv
module dest_match_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        msg_valid = 0;
  logic [1:0]  msg_shorthand = 0;
  logic        msg_logical = 0;
  logic [7:0]  msg_dest = 0;
  logic        msg_self = 0;
  logic        hit_vld, hit, fmt_bad;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dest_match dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
    .msg_shorthand(msg_shorthand), .msg_logical(msg_logical),
    .msg_dest(msg_dest), .msg_self(msg_self), .hit_vld(hit_vld),
    .hit(hit), .fmt_bad(fmt_bad)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [1:0] sel, input logic [31:0] exp);
    @(negedge clk);
    reg_sel = sel;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic send(input string tag, input logic [1:0] sh, input logic lg,
                      input logic [7:0] d, input logic sf, input logic exp);
    @(negedge clk);
    msg_valid = 1; msg_shorthand = sh; msg_logical = lg; msg_dest = d; msg_self = sf;
    @(negedge clk);
    msg_valid = 0;
    chk({tag, " vld"}, {31'd0, hit_vld}, 32'd1);
    chk(tag, {31'd0, hit}, {31'd0, exp});
  endtask

  task automatic t_reset;
    chk("R1 hit_vld", {31'd0, hit_vld}, 0);
    chk("R1 hit", {31'd0, hit}, 0);
    rd("R1 id", 2'd0, 32'h0);
    rd("R1 ldr", 2'd1, 32'h0);
    rd("R1 fmt", 2'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_phys;
    wr(2'd0, 32'h2A00_0000);
    send("R2 own id", 2'b00, 0, 8'h2A, 0, 1);
    send("R2 bcast", 2'b00, 0, 8'hFF, 0, 1);
    send("R2 other", 2'b00, 0, 8'h2B, 0, 0);
  endtask

  task automatic t_flat;
    wr(2'd1, 32'h2400_0000);
    send("R3 flat overlap", 2'b00, 1, 8'h04, 0, 1);
    send("R3 flat disjoint", 2'b00, 1, 8'hDB, 0, 0);
  endtask

  task automatic t_cluster;
    wr(2'd2, 32'h0000_0000);
    rd("R6 fmt cluster", 2'd2, 32'h0FFF_FFFF);
    chk("R7 cluster ok", {31'd0, fmt_bad}, 0);
    wr(2'd1, 32'h3500_0000);
    send("R4 same cluster", 2'b00, 1, 8'h31, 0, 1);
    send("R4 other cluster", 2'b00, 1, 8'h21, 0, 0);
    send("R4 no member", 2'b00, 1, 8'h3A, 0, 0);
  endtask

  task automatic t_badfmt;
    wr(2'd2, 32'h5000_0000);
    rd("R6 fmt forced", 2'd2, 32'h5FFF_FFFF);
    chk("R7 flag", {31'd0, fmt_bad}, 1);
    send("R7 logical blocked", 2'b00, 1, 8'h35, 0, 0);
    send("R7 phys still", 2'b00, 0, 8'hFF, 0, 1);
    wr(2'd2, 32'hF000_1234);
    rd("R6 fmt flat", 2'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_short;
    send("R5 self yes", 2'b01, 0, 8'h00, 1, 1);
    send("R5 self no", 2'b01, 0, 8'h2A, 0, 0);
    send("R5 allinc", 2'b10, 1, 8'h00, 0, 1);
    send("R5 allinc self", 2'b10, 0, 8'h00, 1, 1);
    send("R5 allbut other", 2'b11, 0, 8'h2A, 0, 1);
    send("R5 allbut self", 2'b11, 0, 8'hFF, 1, 0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    chk("R8 idle vld", {31'd0, hit_vld}, 0);
    chk("R8 idle hit", {31'd0, hit}, 0);
  endtask

  task automatic t_sel3;
    wr(2'd3, 32'hDEAD_BEEF);
    rd("R9 sel3", 2'd3, 32'h0);
    rd("R9 id kept", 2'd0, 32'h2A00_0000);
    rd("R9 ldr kept", 2'd1, 32'h3500_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_phys;
    t_flat;
    t_cluster;
    t_badfmt;
    t_short;
    t_timing;
    t_sel3;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule